// File: doc/BRIEF.md
# Accumulator Register-Operation Executor

This block carries out the accumulator instructions that need no memory operand. The processor's sequencer hands it a 12-bit operation field, in which each bit selects one operation, together with the present accumulator value and the carry/link bit. It also raises a one-cycle strobe. While the strobe is high, the block drives the accumulator and link values that should be written back, and a skip request that tells the program-counter logic to advance by one more word. It also records a halt.

The available operations are clearing or inverting the accumulator or the link bit, rotating the 17-bit ring formed by the link bit and the accumulator in either direction, and incrementing the accumulator. Four skip tests look at the accumulator's sign bit, check whether the accumulator is zero, or check whether the link bit is clear. One operation stops the processor. Normally exactly one bit is set. If more than one is set, only the lowest-numbered set bit acts. The write-back values and the skip request are combinational. Only the halt flag is held in a register.

Top module: `rrx_exec`

## Requirements
- R1: With the strobe high and bit 11 the lowest set bit, accNext is 0 and linkNext equals linkIn.
- R2: With the strobe high and bit 10 the lowest set bit, linkNext is 0 and accNext equals accIn.
- R3: With the strobe high, bit 9 as the lowest set bit drives accNext to the bitwise inverse of accIn. Bit 8 as the lowest set bit drives linkNext to the inverse of linkIn. In both cases the other output is unchanged.
- R4: With the strobe high and bit 7 the lowest set bit, accNext = {linkIn, accIn[15:1]} and linkNext = accIn[0].
- R5: With the strobe high and bit 6 the lowest set bit, accNext = {accIn[14:0], linkIn} and linkNext = accIn[15].
- R6: With the strobe high and bit 5 the lowest set bit, accNext = accIn + 1 modulo 2^16, so 0xFFFF wraps to 0x0000, and linkNext equals linkIn.
- R7: Bit 4 as the lowest set bit raises skipReq when accIn[15] is 0. Bit 3 as the lowest set bit raises skipReq when accIn[15] is 1. Both need the strobe high.
- R8: Bit 2 as the lowest set bit raises skipReq when accIn is zero. Bit 1 as the lowest set bit raises skipReq when linkIn is 0. Both need the strobe high.
- R9: halted is 0 after reset. A strobe with bit 0 as the lowest set bit sets halted from the next cycle on, and it stays set until reset.
- R10: When several bits are set, only the lowest-numbered set bit takes effect. For example, 0x820 increments the accumulator and 0x801 only halts, leaving the accumulator and link unchanged.
- R11: With the strobe low, accNext equals accIn, linkNext equals linkIn, skipReq is 0 and halted keeps its value, whatever the operation field holds.
- R12: Every skip, halt and non-selected case passes accIn and linkIn through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opStrobe | input | 1 | Execute the operation field in this cycle |
| opField | input | 12 | One-hot operation select |
| accIn | input | 16 | Current accumulator |
| linkIn | input | 1 | Current carry/link bit |
| accNext | output | 16 | Accumulator value to write back |
| linkNext | output | 1 | Link value to write back |
| skipReq | output | 1 | Advance the program counter by one extra word |
| halted | output | 1 | Sticky halt flag |

## Verification
Two operations can be strobed in the same cycle by setting two bits of the operation field, which the sequencer is never meant to do. The bench pairs an accumulator clear with an increment, a clear with a halt, and a skip with a complement. It judges the outcome against a behavioural model that scans upward from bit 0 and applies only the first set bit it finds. A second overlap is a new operation executed while the halt flag is already set. Here the bench checks that the write-back values are still correct and that the flag neither drops nor interferes with them.

// File: rtl/rrx_pkg.sv
package rrx_pkg;
  localparam int OP_W = 12;
  localparam int DATA_W = 16;

  // bit positions in the operation field; priority is lowest index first
  localparam int B_HALT = 0;
  localparam int B_SKPE = 1;
  localparam int B_SKPZ = 2;
  localparam int B_SKPN = 3;
  localparam int B_SKPP = 4;
  localparam int B_INC = 5;
  localparam int B_ROTL = 6;
  localparam int B_ROTR = 7;
  localparam int B_CMPE = 8;
  localparam int B_CMPA = 9;
  localparam int B_CLRE = 10;
  localparam int B_CLRA = 11;

  typedef struct packed {
    logic clrAcc;
    logic clrLink;
    logic cmpAcc;
    logic cmpLink;
    logic rotR;
    logic rotL;
    logic incAcc;
    logic skipPos;
    logic skipNeg;
    logic skipZero;
    logic skipLinkZ;
  } exStrobes_t;
endpackage

// File: rtl/rrx_ctrl.sv
module rrx_ctrl
  import rrx_pkg::*;
#(
  parameter int OPW = OP_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           opStrobe,
  input  logic [OPW-1:0] opField,
  output exStrobes_t     strobes,
  output logic           halted
);
  logic [OPW-1:0] lowest;
  logic [OPW-1:0] sel;
  logic haltQ;

  // isolate the lowest set bit
  always_comb begin
    lowest = opField & (~opField + {{(OPW-1){1'b0}}, 1'b1});
    sel = opStrobe ? lowest : '0;
  end

  always_comb begin
    strobes.clrAcc    = sel[B_CLRA];
    strobes.clrLink   = sel[B_CLRE];
    strobes.cmpAcc    = sel[B_CMPA];
    strobes.cmpLink   = sel[B_CMPE];
    strobes.rotR      = sel[B_ROTR];
    strobes.rotL      = sel[B_ROTL];
    strobes.incAcc    = sel[B_INC];
    strobes.skipPos   = sel[B_SKPP];
    strobes.skipNeg   = sel[B_SKPN];
    strobes.skipZero  = sel[B_SKPZ];
    strobes.skipLinkZ = sel[B_SKPE];
  end

  always_ff @(posedge clk) begin
    if (!rstN) haltQ <= 1'b0;
    else       haltQ <= haltQ | sel[B_HALT];
  end

  assign halted = haltQ;
endmodule

// File: rtl/rrx_dpath.sv
module rrx_dpath
  import rrx_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  exStrobes_t    strobes,
  input  logic [DW-1:0] accIn,
  input  logic          linkIn,
  output logic [DW-1:0] accNext,
  output logic          linkNext,
  output logic          skipReq
);
  localparam int MSB = DW - 1;

  logic accIsZero;
  logic accIsNeg;

  always_comb begin
    accNext  = accIn;
    linkNext = linkIn;
    if (strobes.clrAcc)  accNext = '0;
    if (strobes.clrLink) linkNext = 1'b0;
    if (strobes.cmpAcc)  accNext = ~accIn;
    if (strobes.cmpLink) linkNext = ~linkIn;
    if (strobes.rotR)    {accNext, linkNext} = {linkIn, accIn};
    if (strobes.rotL)    {linkNext, accNext} = {accIn, linkIn};
    if (strobes.incAcc)  accNext = accIn + {{(DW-1){1'b0}}, 1'b1};
  end

  always_comb begin
    accIsZero = (accIn == '0);
    accIsNeg  = accIn[MSB];
    skipReq   = (strobes.skipPos & ~accIsNeg)
              | (strobes.skipNeg & accIsNeg)
              | (strobes.skipZero & accIsZero)
              | (strobes.skipLinkZ & ~linkIn);
  end
endmodule

// File: rtl/rrx_exec.sv
module rrx_exec
  import rrx_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opStrobe,
  input  logic [OPW-1:0] opField,
  input  logic [DW-1:0] accIn,
  input  logic          linkIn,
  output logic [DW-1:0] accNext,
  output logic          linkNext,
  output logic          skipReq,
  output logic          halted
);
  exStrobes_t strobes;

  rrx_ctrl #(.OPW(OPW)) u_ctrl (
    .clk(clk), .rstN(rstN), .opStrobe(opStrobe), .opField(opField),
    .strobes(strobes), .halted(halted)
  );

  rrx_dpath #(.DW(DW)) u_dpath (
    .strobes(strobes), .accIn(accIn), .linkIn(linkIn),
    .accNext(accNext), .linkNext(linkNext), .skipReq(skipReq)
  );
endmodule

// File: rtl/rrx_exec_chk.sv
module rrx_exec_chk #(
  parameter int OPW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          opStrobe,
  input logic [OPW-1:0] opField,
  input logic [DW-1:0] accIn,
  input logic          linkIn,
  input logic [DW-1:0] accNext,
  input logic          linkNext,
  input logic          skipReq,
  input logic          halted
);
  localparam logic [OPW-1:0] OP_CLRA = OPW'(1) << 11;
  localparam logic [OPW-1:0] OP_ROTR = OPW'(1) << 7;
  localparam logic [OPW-1:0] OP_ROTL = OPW'(1) << 6;
  localparam logic [OPW-1:0] OP_INC  = OPW'(1) << 5;

  p_clr_acc_r1: assert property (@(posedge clk) disable iff (!rstN)
    (opStrobe && opField == OP_CLRA) |-> (accNext == '0 && linkNext == linkIn));
  p_rot_right_r4: assert property (@(posedge clk) disable iff (!rstN)
    (opStrobe && opField == OP_ROTR) |-> ({accNext, linkNext} == {linkIn, accIn}));
  p_rot_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opStrobe && opField == OP_ROTL) |-> ({linkNext, accNext} == {accIn, linkIn}));
  p_inc_keeps_link_r6: assert property (@(posedge clk) disable iff (!rstN)
    (opStrobe && opField == OP_INC) |-> (linkNext == linkIn));
  p_halt_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    (opStrobe && opField[0]) |=> halted);
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);
  p_idle_pass_r11: assert property (@(posedge clk) disable iff (!rstN)
    !opStrobe |-> (accNext == accIn && linkNext == linkIn && !skipReq));
  p_idle_no_halt_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!opStrobe && !halted) |=> !halted);
  p_halt_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    (opStrobe && opField[0]) |-> (accNext == accIn && linkNext == linkIn && !skipReq));
endmodule

bind rrx_exec rrx_exec_chk #(.OPW(OPW), .DW(DW)) u_chk (
  .clk(clk), .rstN(rstN), .opStrobe(opStrobe), .opField(opField),
  .accIn(accIn), .linkIn(linkIn), .accNext(accNext), .linkNext(linkNext),
  .skipReq(skipReq), .halted(halted)
);

// File: tb/sim_rrx_exec.sv
`timescale 1ns/1ps
module sim_rrx_exec;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opStrobe = 1'b0;
  logic [11:0] opField = '0;
  logic [15:0] accIn = '0;
  logic        linkIn = 1'b0;
  logic [15:0] accNext;
  logic        linkNext;
  logic        skipReq;
  logic        halted;

  int checks = 0;
  int failures = 0;
  bit modelHalt = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rrx_exec u0 (
    .clk(clk), .rstN(rstN), .opStrobe(opStrobe), .opField(opField),
    .accIn(accIn), .linkIn(linkIn), .accNext(accNext), .linkNext(linkNext),
    .skipReq(skipReq), .halted(halted)
  );

  // behavioural reference: find the first set bit from 0 upward, apply it
  function automatic int firstBit(input logic [11:0] f);
    for (int i = 0; i < 12; i++) if (f[i]) return i;
    return -1;
  endfunction

  task automatic model(input bit st, input logic [11:0] f, input logic [15:0] a,
                       input bit e, output logic [15:0] ea, output bit ee,
                       output bit es, output bit eh);
    int b;
    ea = a; ee = e; es = 0; eh = 0;
    b = st ? firstBit(f) : -1;
    case (b)
      11: ea = 16'h0000;
      10: ee = 0;
      9:  ea = ~a;
      8:  ee = ~e;
      7:  begin ea = {e, a[15:1]}; ee = a[0]; end
      6:  begin ea = {a[14:0], e}; ee = a[15]; end
      5:  ea = a + 16'd1;
      4:  es = (a[15] == 1'b0);
      3:  es = (a[15] == 1'b1);
      2:  es = (a == 16'h0000);
      1:  es = (e == 1'b0);
      0:  eh = 1;
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit st, input logic [11:0] f,
                      input logic [15:0] a, input bit e);
    logic [15:0] ea; bit ee, es, eh;
    @(negedge clk);
    opStrobe = st; opField = f; accIn = a; linkIn = e;
    #1;
    model(st, f, a, e, ea, ee, es, eh);
    chk(tag, "accNext", 32'(accNext), 32'(ea));
    chk(tag, "linkNext", 32'(linkNext), 32'(ee));
    chk(tag, "skipReq", 32'(skipReq), 32'(es));
    chk(tag, "halted", 32'(halted), 32'(modelHalt));
    @(posedge clk);
    if (eh) modelHalt = 1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0; opStrobe = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    modelHalt = 0;
    chk("R9", "halted after reset", 32'(halted), 32'd0);
  endtask

  initial begin
    fork
      begin
        #2000000;
        if (!done) begin
          failures++;
          $display("FAIL watchdog expired");
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none

    doReset();
    step("R11", 0, 12'h800, 16'h1234, 1);
    step("R11", 0, 12'h001, 16'h0000, 0);
    step("R1", 1, 12'h800, 16'hBEEF, 1);
    step("R2", 1, 12'h400, 16'h5A5A, 1);
    step("R3", 1, 12'h200, 16'h0F0F, 0);
    step("R3", 1, 12'h100, 16'h0F0F, 1);
    step("R4", 1, 12'h080, 16'h0001, 0);
    step("R4", 1, 12'h080, 16'h8000, 1);
    step("R5", 1, 12'h040, 16'h8000, 0);
    step("R5", 1, 12'h040, 16'h4001, 1);
    step("R6", 1, 12'h020, 16'hFFFF, 1);
    step("R6", 1, 12'h020, 16'h00FF, 0);
    step("R7", 1, 12'h010, 16'h7FFF, 0);
    step("R7", 1, 12'h010, 16'h8000, 0);
    step("R7", 1, 12'h010, 16'h0000, 1);
    step("R7", 1, 12'h008, 16'h8000, 0);
    step("R7", 1, 12'h008, 16'h7FFF, 0);
    step("R8", 1, 12'h004, 16'h0000, 1);
    step("R8", 1, 12'h004, 16'h0001, 1);
    step("R8", 1, 12'h002, 16'h1234, 0);
    step("R8", 1, 12'h002, 16'h1234, 1);
    step("R10", 1, 12'h820, 16'h0041, 1);
    step("R10", 1, 12'h210, 16'h8000, 0);
    step("R10", 1, 12'h0C0, 16'h8001, 0);
    step("R12", 1, 12'h000, 16'hCAFE, 1);
    for (int i = 0; i < 40; i++)
      step("R12", 1, 12'(1 << (i % 12)) | 12'(i * 37 & 12'hFFE), 16'(i * 16'h2A63), i[0]);
    doReset();
    step("R10", 1, 12'h801, 16'h1357, 1);
    step("R9", 1, 12'h000, 16'h1357, 1);
    step("R9", 1, 12'h001, 16'h0000, 0);
    step("R9", 0, 12'h000, 16'h0001, 0);
    step("R9", 1, 12'h020, 16'h0009, 0);
    doReset();
    step("R9", 0, 12'h001, 16'h0000, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule